// File: doc/BRIEF.md
# Interrupt Status Collector with Toggle-on-Write Acknowledge

This block gathers single-cycle event pulses from a serial bus controller into a per-source pending register. Each source has its own enable bit, and one global enable sits over all of them. Together they form a single level-sensitive interrupt line. Software reaches the block through a simple synchronous register port. The port has a write strobe, a read strobe, a byte address and a data word. Four words are decoded: global enable at 0x1C, pending status at 0x20, source enable at 0x28, and a soft-reset trigger at 0x40.

The pending register does not load the value written to it. A write instead inverts every bit written as one, and bits written as zero are left as they are. A handler acknowledges a source by writing back the bits it has serviced. The same write can also set a bit that is clear, which raises a software-made interrupt for testing or deferred work. Events always land in the pending register, so it can be polled with every enable off.

There are eight sources in the default build. Their bit positions are: 0 arbitration lost, 1 transmit error or message done, 2 transmit queue empty, 3 receive queue at threshold, 4 bus idle, 5 selected as target, 6 no longer selected as target, 7 transmit queue half empty.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the pending, enable and global-enable registers are zero, `irq_o` is 0 and `rd_data_o` is 0.
- R2: An event pulse on `evt_i[i]` sets pending bit i on the next clock edge, whatever the state of the enables. Bit i of the word read at 0x20 then returns 1.
- R3: A write to 0x20 inverts each pending bit whose `wr_data_i` bit is 1 and leaves the others unchanged. A bit that goes from 0 to 1 this way counts as pending like any event.
- R4: If an event and a toggle write hit the same pending bit in the same cycle, the bit is 1 afterwards.
- R5: A write to 0x28 loads the source enables from `wr_data_i[N_SRC-1:0]`, and a read of 0x28 returns them in the same bit positions as the pending register.
- R6: `irq_o` is registered. One cycle after any register change it equals global enable AND the OR of (pending AND enable).
- R7: The global enable is bit 31 of the word at 0x1C, and every other bit of that word reads as 0. Writing 0 there forces `irq_o` low and leaves the source enables and pending bits unchanged.
- R8: Writing 0x0000000A to 0x40 clears the pending, enable and global-enable registers, and this takes priority over an event in the same cycle. A write of any other value to 0x40 changes nothing.
- R9: A read of any address other than 0x1C, 0x20 and 0x28 returns 0, 0x40 included. A write to any undecoded address changes no register.
- R10: `rd_data_o` shows the addressed word in the cycle after `rd_en_i` is sampled, and is 0 in every cycle that follows a clock edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_SRC | One-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the register word |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt line, active high |

## Verification
Register contents change at the clock edge that samples a write or an event. Read data comes one edge after the read strobe. The interrupt line trails any register change by one more edge. The bench therefore drives every stimulus for exactly one edge and samples a moment after that edge. It always checks the line after one idle edge that follows the last write or event, and checks read data right after the read edge. Sweeps cover all 256 starting pending patterns against a varied toggle mask, and all 256 enable masks against a varied pending pattern. The resulting pending and enable words are read back, and the interrupt line is compared with a value the bench computes itself.

// File: rtl/irq_blk_pkg.sv
`timescale 1ns/1ps
package irq_blk_pkg;

  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_N_SRC  = 8;

  // Word offsets decoded by the register port
  localparam logic [DEF_ADDR_W-1:0] OFS_GLB = 8'h1C;
  localparam logic [DEF_ADDR_W-1:0] OFS_PND = 8'h20;
  localparam logic [DEF_ADDR_W-1:0] OFS_ENA = 8'h28;
  localparam logic [DEF_ADDR_W-1:0] OFS_SRT = 8'h40;

  // Value that must be written to the soft-reset word
  localparam logic [DEF_DATA_W-1:0] SRT_KEY = 32'h0000_000A;

  // Source bit positions
  localparam int unsigned SRC_ARB_LOST  = 0;
  localparam int unsigned SRC_TX_ERR    = 1;
  localparam int unsigned SRC_TXQ_EMPTY = 2;
  localparam int unsigned SRC_RXQ_LEVEL = 3;
  localparam int unsigned SRC_BUS_IDLE  = 4;
  localparam int unsigned SRC_TGT_SEL   = 5;
  localparam int unsigned SRC_TGT_DESEL = 6;
  localparam int unsigned SRC_TXQ_HALF  = 7;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_GLB  = 2'd1,
    RSEL_PND  = 2'd2,
    RSEL_ENA  = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic wr_glb;
    logic wr_pnd;
    logic wr_ena;
    logic soft_rst;
  } wr_strb_t;

endpackage

// File: rtl/irq_regdec.sv
`timescale 1ns/1ps
module irq_regdec
  import irq_blk_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] A_GLB = OFS_GLB,
  parameter logic [ADDR_W-1:0] A_PND = OFS_PND,
  parameter logic [ADDR_W-1:0] A_ENA = OFS_ENA,
  parameter logic [ADDR_W-1:0] A_SRT = OFS_SRT,
  parameter logic [DATA_W-1:0] KEY   = SRT_KEY
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output wr_strb_t          strb,
  output rd_sel_e           rd_sel
);

  always_comb begin
    strb          = '0;
    strb.wr_glb   = wr_en && (addr == A_GLB);
    strb.wr_pnd   = wr_en && (addr == A_PND);
    strb.wr_ena   = wr_en && (addr == A_ENA);
    strb.soft_rst = wr_en && (addr == A_SRT) && (wdata == KEY);
  end

  always_comb begin
    rd_sel = RSEL_NONE;
    if (rd_en) begin
      if (addr == A_GLB)      rd_sel = RSEL_GLB;
      else if (addr == A_PND) rd_sel = RSEL_PND;
      else if (addr == A_ENA) rd_sel = RSEL_ENA;
      else                    rd_sel = RSEL_NONE;
    end
  end

endmodule

// File: rtl/irq_pending_bank.sv
`timescale 1ns/1ps
module irq_pending_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [N_SRC-1:0] evt,
  input  logic             tog_en,
  input  logic [N_SRC-1:0] tog,
  output logic [N_SRC-1:0] pnd_q
);

  // One flop per source: toggle first, then the event ORs in so it is never lost.
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic flip;
    assign flip = tog_en & tog[i];
    always_ff @(posedge clk) begin
      if (rst || clr) pnd_q[i] <= 1'b0;
      else            pnd_q[i] <= (pnd_q[i] ^ flip) | evt[i];
    end
  end

endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_ena,
  input  logic [N_SRC-1:0] ena_d,
  input  logic             wr_glb,
  input  logic             glb_d,
  output logic [N_SRC-1:0] ena_q,
  output logic             glb_q
);

  always_ff @(posedge clk) begin
    if (rst || clr)  ena_q <= '0;
    else if (wr_ena) ena_q <= ena_d;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  glb_q <= 1'b0;
    else if (wr_glb) glb_q <= glb_d;
  end

endmodule

// File: rtl/irq_line.sv
`timescale 1ns/1ps
module irq_line #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb,
  input  logic [N_SRC-1:0] pnd,
  input  logic [N_SRC-1:0] ena,
  output logic             irq_q
);

  logic any_live;
  assign any_live = |(pnd & ena);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= glb & any_live;
  end

endmodule

// File: rtl/irq_toggle_ctrl.sv
`timescale 1ns/1ps
module irq_toggle_ctrl
  import irq_blk_pkg::*;
#(
  parameter int unsigned N_SRC  = DEF_N_SRC,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);

  localparam int unsigned GLB_BIT = DATA_W - 1;

  wr_strb_t         strb;
  rd_sel_e          rd_sel;
  logic [N_SRC-1:0] pnd_q;
  logic [N_SRC-1:0] ena_q;
  logic             glb_q;
  logic [DATA_W-1:0] rd_word;

  irq_regdec #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dec (
    .wr_en (wr_en_i),
    .rd_en (rd_en_i),
    .addr  (addr_i),
    .wdata (wr_data_i),
    .strb  (strb),
    .rd_sel(rd_sel)
  );

  irq_pending_bank #(.N_SRC(N_SRC)) u_pnd (
    .clk   (clk),
    .rst   (rst),
    .clr   (strb.soft_rst),
    .evt   (evt_i),
    .tog_en(strb.wr_pnd),
    .tog   (wr_data_i[N_SRC-1:0]),
    .pnd_q (pnd_q)
  );

  irq_ctrl_regs #(.N_SRC(N_SRC)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .clr   (strb.soft_rst),
    .wr_ena(strb.wr_ena),
    .ena_d (wr_data_i[N_SRC-1:0]),
    .wr_glb(strb.wr_glb),
    .glb_d (wr_data_i[GLB_BIT]),
    .ena_q (ena_q),
    .glb_q (glb_q)
  );

  irq_line #(.N_SRC(N_SRC)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .glb  (glb_q),
    .pnd  (pnd_q),
    .ena  (ena_q),
    .irq_q(irq_o)
  );

  always_comb begin
    rd_word = '0;
    case (rd_sel)
      RSEL_GLB: rd_word[GLB_BIT]   = glb_q;
      RSEL_PND: rd_word[N_SRC-1:0] = pnd_q;
      RSEL_ENA: rd_word[N_SRC-1:0] = ena_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_word;
  end

endmodule

// File: rtl/irq_toggle_chk.sv
`timescale 1ns/1ps
module irq_toggle_chk #(
  parameter int unsigned N_SRC = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] evt,
  input logic             wr_pnd,
  input logic             soft_rst,
  input logic [N_SRC-1:0] tog,
  input logic [N_SRC-1:0] pnd_q,
  input logic [N_SRC-1:0] ena_q,
  input logic             glb_q,
  input logic             irq
);

  // R2 / R4: an event always leaves its bit set unless a soft reset wins
  a_r4_event_kept: assert property (@(posedge clk) disable iff (rst)
    (|evt && !soft_rst) |=> ((pnd_q & $past(evt)) == $past(evt)));

  // R3: a toggle write with no event flips exactly the written ones
  a_r3_toggle_exact: assert property (@(posedge clk) disable iff (rst)
    (wr_pnd && !soft_rst && evt == '0) |=> ((pnd_q ^ $past(pnd_q)) == $past(tog)));

  // R6: line follows gated state one edge later
  a_r6_line_tracks: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(glb_q && (|(pnd_q & ena_q)))));

  // R7: global enable off forces the line low next cycle
  a_r7_glb_masks: assert property (@(posedge clk) disable iff (rst)
    !glb_q |=> !irq);

  // R8: soft reset empties all state
  a_r8_soft_clear: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (pnd_q == '0 && ena_q == '0 && !glb_q));

endmodule

bind irq_toggle_ctrl irq_toggle_chk #(.N_SRC(N_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .evt     (evt_i),
  .wr_pnd  (strb.wr_pnd),
  .soft_rst(strb.soft_rst),
  .tog     (wr_data_i[N_SRC-1:0]),
  .pnd_q   (pnd_q),
  .ena_q   (ena_q),
  .glb_q   (glb_q),
  .irq     (irq_o)
);

// File: tb/irq_toggle_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_toggle_ctrl_tb_top;
  localparam int N = 8;
  localparam logic [7:0] A_GLB = 8'h1C, A_PND = 8'h20, A_ENA = 8'h28, A_SRT = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] evt = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0, fails = 0;
  logic [N-1:0] m_pnd = '0, m_ena = '0;
  logic         m_glb = 1'b0;

  always #2.5 clk = ~clk;

  irq_toggle_ctrl dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic exp_irq();
    return m_glb && (|(m_pnd & m_ena));
  endfunction

  task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [N-1:0] e);
    wr_en = 1'b1; addr = a; wdata = d; evt = e;
    tick();
    wr_en = 1'b0; evt = '0; wdata = '0;
    if (a == A_SRT && d == 32'hA) begin
      m_pnd = '0; m_ena = '0; m_glb = 1'b0;
    end else begin
      if (a == A_PND) m_pnd = m_pnd ^ d[N-1:0];
      if (a == A_ENA) m_ena = d[N-1:0];
      if (a == A_GLB) m_glb = d[31];
      m_pnd = m_pnd | e;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_evt(a, d, '0);
  endtask

  task automatic pulse(input logic [N-1:0] e);
    evt = e; tick(); evt = '0;
    m_pnd = m_pnd | e;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic irq_chk(input string req);
    tick();
    chk(req, {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  task automatic set_pnd(input logic [N-1:0] v);
    if (m_pnd != v) wr(A_PND, {24'b0, m_pnd ^ v});
  endtask

  initial begin
    #(5.0 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) tick();
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    chk("R1 rdata in reset", rdata, 32'h0);
    rst = 1'b0;
    tick();
    chk("R1 irq after release", {31'b0, irq}, 32'h0);
    rd_chk(A_PND, 32'h0, "R1 pending");
    rd_chk(A_ENA, 32'h0, "R1 enable");
    rd_chk(A_GLB, 32'h0, "R1 global");

    // R10: latency and idle zero
    wr(A_ENA, 32'h3C);
    rd_chk(A_ENA, 32'h3C, "R10 read one edge later");
    tick();
    chk("R10 idle rdata", rdata, 32'h0);

    // R2: each source sets its bit with enables off
    wr(A_ENA, 32'h0);
    for (int i = 0; i < N; i++) begin
      pulse(N'(1) << i);
      rd_chk(A_PND, {24'b0, m_pnd}, "R2 event sets pending");
      irq_chk("R2 no line with enables off");
    end
    chk("R2 all sources seen", {24'b0, m_pnd}, 32'hFF);

    // R3: toggle sweep over all starting patterns
    for (int s = 0; s < 256; s++) begin
      logic [N-1:0] t;
      set_pnd(N'(s));
      t = N'(s * 37 + 11);
      wr(A_PND, {24'b0, t});
      rd_chk(A_PND, {24'b0, N'(s) ^ t}, "R3 toggle result");
    end

    // R4: event and toggle same bit same cycle
    set_pnd(8'h08);
    wr_evt(A_PND, 32'h18, 8'h18);
    rd_chk(A_PND, 32'h18, "R4 event wins over toggle");
    set_pnd(8'h00);
    wr_evt(A_PND, 32'h81, 8'h01);
    rd_chk(A_PND, 32'h81, "R4 clear bit toggled with event");

    // R5 / R6: enable sweep with global enable on
    wr(A_GLB, 32'h8000_0000);
    for (int e = 0; e < 256; e++) begin
      wr(A_ENA, {24'b0, N'(e)});
      set_pnd(N'(e * 53 + 7));
      rd_chk(A_ENA, {24'b0, N'(e)}, "R5 enable readback");
      irq_chk("R6 line equals gated state");
    end

    // R3 software raise then acknowledge
    wr(A_ENA, 32'h04); set_pnd(8'h00); irq_chk("R6 idle line");
    wr(A_PND, 32'h04); irq_chk("R3 software raised interrupt");
    chk("R3 line high", {31'b0, irq}, 32'h1);
    wr(A_PND, 32'h04); irq_chk("R3 acknowledge drops line");
    chk("R3 line low", {31'b0, irq}, 32'h0);

    // R7: global enable
    wr(A_ENA, 32'hFF); set_pnd(8'h21); irq_chk("R7 line on");
    wr(A_GLB, 32'h7FFF_FFFF);
    irq_chk("R7 global off masks");
    chk("R7 masked value", {31'b0, irq}, 32'h0);
    rd_chk(A_GLB, 32'h0, "R7 only bit 31 counts");
    rd_chk(A_ENA, 32'hFF, "R7 enables kept");
    rd_chk(A_PND, 32'h21, "R7 pending kept");
    wr(A_GLB, 32'hFFFF_FFFF);
    rd_chk(A_GLB, 32'h8000_0000, "R7 readback other bits zero");
    irq_chk("R7 line restored");

    // R8: soft reset
    wr(A_SRT, 32'h5);
    rd_chk(A_PND, 32'h21, "R8 wrong key pending");
    rd_chk(A_ENA, 32'hFF, "R8 wrong key enable");
    rd_chk(A_GLB, 32'h8000_0000, "R8 wrong key global");
    wr(A_SRT, 32'h1000_000A);
    rd_chk(A_PND, 32'h21, "R8 upper bits break key");
    wr_evt(A_SRT, 32'hA, 8'h40);
    rd_chk(A_PND, 32'h0, "R8 cleared pending despite event");
    rd_chk(A_ENA, 32'h0, "R8 cleared enable");
    rd_chk(A_GLB, 32'h0, "R8 cleared global");
    irq_chk("R8 line low");

    // R9: undecoded addresses
    wr(A_ENA, 32'h0F); set_pnd(8'hA5);
    rd_chk(8'h00, 32'h0, "R9 read 0x00");
    rd_chk(8'h24, 32'h0, "R9 read 0x24");
    rd_chk(A_SRT, 32'h0, "R9 read reset word");
    rd_chk(8'hFC, 32'h0, "R9 read 0xFC");
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    rd_chk(A_PND, 32'hA5, "R9 write ignored pending");
    rd_chk(A_ENA, 32'h0F, "R9 write ignored enable");
    rd_chk(A_GLB, 32'h0, "R9 write ignored global");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule